// File: doc/BRIEF.md
# Write-Aware Bank Request Scheduler

This block decides which request a single last-level cache bank serves next, for a bank whose writes take far longer than its reads. Requests arrive on four class ports: demand read, demand fill, prefetch fill and writeback. Each port feeds a small in-order queue. One request at a time is issued to the bank. The block then counts the cycles of the bank operation and emits a one-cycle completion pulse when the operation's latency has elapsed.

A write in progress that belongs to a less critical class can be cut short when a more critical request is waiting. This is allowed only while the fraction of the write's latency already spent is below a per-class progress threshold. The interrupted write is not removed from its queue. It stays at the head and is issued again later, ahead of any younger request of its class. A selector input picks between strict ordering and a scheme in which demand reads and demand fills share the top rank and alternate.

Top module: `bank_req_sched`

## Requirements
- R1: With `tie_top` low, an idle scheduler grants the most critical non-empty class, in the order read (class code 0) > demand fill (1) > prefetch fill (2) > writeback (3).
- R2: With `tie_top` high, read and demand fill have equal rank above prefetch fill, which is above writeback. When both a read and a demand fill are queued, they are served alternately, starting with the read after reset.
- R3: Within each class, requests are issued in arrival order. `req_ready` for a class is low exactly when its queue of `DEPTH` entries is full. An entry occupies its queue slot until its operation completes.
- R4: If `cmd_valid` is high in cycle c, then `op_done` pulses in cycle c+`RD_LAT` for a read, or in cycle c+`WR_LAT` for any of the three write classes, unless the operation is aborted first.
- R5: A write of class k in service is aborted when a strictly higher-ranked class has a queued request while `elapsed*100 < THR_k*WR_LAT`. Here `elapsed` counts the cycles since the grant. The abort shows as a one-cycle `op_abort` pulse. With the defaults, the thresholds are 60 for demand fill, 60 for prefetch fill and 25 for writeback.
- R6: An aborted write remains at the head of its class queue and is issued again with the same address, before any younger request of that class.
- R7: A read in service is never aborted.
- R8: A new grant appears no earlier than the cycle after the `op_done` or `op_abort` pulse of the previous operation, and never in the same cycle as either pulse.
- R9: `preempt_total` increases by exactly one in each cycle in which `op_abort` is high, and is otherwise unchanged.
- R10: While reset is high, `cmd_valid`, `op_done` and `op_abort` are low, every `req_ready` bit is high, and `preempt_total` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tie_top | input | 1 | 1 selects equal rank for read and demand fill |
| req_valid | input | 4 | Per-class request valid, bit index is the class code |
| req_ready | output | 4 | Per-class queue can accept a request |
| req_addr | input | 4*AW | Per-class request address, class k in bits [k*AW +: AW] |
| cmd_valid | output | 1 | One-cycle pulse: an operation is issued to the bank |
| cmd_cls | output | 2 | Class code of the issued operation |
| cmd_addr | output | AW | Address of the issued operation |
| op_done | output | 1 | One-cycle pulse: the current operation finished |
| op_abort | output | 1 | One-cycle pulse: the current write was preempted |
| preempt_total | output | PC_W | Number of preemptions since reset |

## Verification
The two functions that can fall in the same cycle are the arrival of a more critical request and the threshold test on the write in service. The bench waits for a write grant and then injects a read a chosen number of cycles later, so that the arrival lands on the last cycle where progress is still below the threshold, or on the first cycle where it is not. It then judges the exact abort cycle, the counter step and the reissue order, or, in the other case, an undisturbed completion after the full write latency. A similar collision, a queued demand fill while a read is in service in tie mode, is used to confirm that equal-ranked work never interrupts.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;

    localparam int NUM_CLS  = 4;
    localparam int CLS_W    = 2;
    localparam int PCT_FULL = 100;

    typedef enum logic [CLS_W-1:0] {
        CLS_RD   = 2'd0,
        CLS_FILL = 2'd1,
        CLS_PF   = 2'd2,
        CLS_WB   = 2'd3
    } req_cls_e;

    typedef struct packed {
        logic     busy;
        req_cls_e cls;
    } op_state_t;

    // Rank 0 is the most critical; tie mode merges read and demand fill.
    function automatic logic [1:0] rank_of(req_cls_e c, logic tie);
        logic [1:0] r;
        if (!tie) begin
            r = c;
        end else begin
            case (c)
                CLS_RD, CLS_FILL: r = 2'd0;
                CLS_PF:           r = 2'd1;
                default:          r = 2'd2;
            endcase
        end
        return r;
    endfunction

    function automatic logic is_write(req_cls_e c);
        return c != CLS_RD;
    endfunction

endpackage

// File: rtl/bank_class_fifo.sv
module bank_class_fifo #(
    parameter int AW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] slot [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   fill_cnt;
    logic          do_push, do_pop;

    assign empty     = (fill_cnt == '0);
    assign full      = (fill_cnt == (PW+1)'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_addr = slot[rd_ptr];

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (do_push) begin
                slot[wr_ptr] <= push_addr;
                wr_ptr       <= nxt(wr_ptr);
            end
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      fill_cnt <= fill_cnt + 1'b1;
            else if (do_pop && !do_push) fill_cnt <= fill_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/bank_grant_select.sv
module bank_grant_select
    import bank_sched_pkg::*;
(
    input  logic [NUM_CLS-1:0] nonempty,
    input  logic               tie,
    input  logic               rr_fill,
    output logic               sel_valid,
    output req_cls_e           sel_cls
);
    always_comb begin
        sel_valid = |nonempty;
        sel_cls   = CLS_WB;
        for (int c = NUM_CLS - 1; c >= 0; c--) begin
            if (nonempty[c]) sel_cls = req_cls_e'(c[CLS_W-1:0]);
        end
        if (tie && nonempty[CLS_RD] && nonempty[CLS_FILL]) begin
            sel_cls = rr_fill ? CLS_FILL : CLS_RD;
        end
    end
endmodule

// File: rtl/bank_preempt_check.sv
module bank_preempt_check
    import bank_sched_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int WR_LAT   = 20,
    parameter int THR_FILL = 60,
    parameter int THR_PF   = 60,
    parameter int THR_WB   = 25
) (
    input  logic               busy,
    input  req_cls_e           cur_cls,
    input  logic [CNT_W-1:0]   elapsed,
    input  logic [NUM_CLS-1:0] nonempty,
    input  logic               tie,
    output logic               preempt
);
    logic higher_waiting;
    logic below_mark;
    int   thr_cur;

    always_comb begin
        higher_waiting = 1'b0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (nonempty[c] &&
                rank_of(req_cls_e'(c[CLS_W-1:0]), tie) < rank_of(cur_cls, tie))
                higher_waiting = 1'b1;
        end
    end

    always_comb begin
        case (cur_cls)
            CLS_FILL: thr_cur = THR_FILL;
            CLS_PF:   thr_cur = THR_PF;
            CLS_WB:   thr_cur = THR_WB;
            default:  thr_cur = 0;
        endcase
    end

    // Cross-multiplied progress test, no divider.
    assign below_mark = (int'(elapsed) * PCT_FULL) < (thr_cur * WR_LAT);
    assign preempt    = busy && is_write(cur_cls) && higher_waiting && below_mark;
endmodule

// File: rtl/bank_req_sched.sv
module bank_req_sched
    import bank_sched_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DEPTH    = 4,
    parameter int RD_LAT   = 12,
    parameter int WR_LAT   = 20,
    parameter int THR_FILL = 60,
    parameter int THR_PF   = 60,
    parameter int THR_WB   = 25,
    parameter int PC_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tie_top,
    input  logic [3:0]            req_valid,
    output logic [3:0]            req_ready,
    input  logic [4*AW-1:0]       req_addr,
    output logic                  cmd_valid,
    output logic [1:0]            cmd_cls,
    output logic [AW-1:0]         cmd_addr,
    output logic                  op_done,
    output logic                  op_abort,
    output logic [PC_W-1:0]       preempt_total
);
    localparam int MAX_LAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LAT - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LAT - 1);

    op_state_t          op_q;
    logic [CNT_W-1:0]   elapsed;
    logic               rr_fill;
    logic [NUM_CLS-1:0] nonempty, full_v, pop_v;
    logic [AW-1:0]      head_addr [NUM_CLS];
    logic               sel_valid, preempt, finishing;
    req_cls_e           sel_cls;
    logic               busy_w;
    logic [1:0]         cur_cls_w;

    assign busy_w    = op_q.busy;
    assign cur_cls_w = op_q.cls;
    assign finishing = op_q.busy &&
                       (elapsed == ((op_q.cls == CLS_RD) ? RD_LAST : WR_LAST));

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_q
        logic empty_g;
        bank_class_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (req_valid[g]),
            .push_addr (req_addr[g*AW +: AW]),
            .pop       (pop_v[g]),
            .head_addr (head_addr[g]),
            .empty     (empty_g),
            .full      (full_v[g])
        );
        assign nonempty[g]  = !empty_g;
        assign req_ready[g] = !full_v[g];
        assign pop_v[g]     = finishing && (op_q.cls == req_cls_e'(g));
    end

    bank_grant_select u_sel (
        .nonempty  (nonempty),
        .tie       (tie_top),
        .rr_fill   (rr_fill),
        .sel_valid (sel_valid),
        .sel_cls   (sel_cls)
    );

    bank_preempt_check #(
        .CNT_W(CNT_W), .WR_LAT(WR_LAT),
        .THR_FILL(THR_FILL), .THR_PF(THR_PF), .THR_WB(THR_WB)
    ) u_pre (
        .busy     (op_q.busy),
        .cur_cls  (op_q.cls),
        .elapsed  (elapsed),
        .nonempty (nonempty),
        .tie      (tie_top),
        .preempt  (preempt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q          <= '{busy: 1'b0, cls: CLS_RD};
            elapsed       <= '0;
            rr_fill       <= 1'b0;
            cmd_valid     <= 1'b0;
            cmd_cls       <= '0;
            cmd_addr      <= '0;
            op_done       <= 1'b0;
            op_abort      <= 1'b0;
            preempt_total <= '0;
        end else begin
            cmd_valid <= 1'b0;
            op_done   <= 1'b0;
            op_abort  <= 1'b0;
            if (!op_q.busy) begin
                if (sel_valid) begin
                    op_q      <= '{busy: 1'b1, cls: sel_cls};
                    elapsed   <= '0;
                    cmd_valid <= 1'b1;
                    cmd_cls   <= sel_cls;
                    cmd_addr  <= head_addr[sel_cls];
                    if (sel_cls == CLS_RD || sel_cls == CLS_FILL)
                        rr_fill <= (sel_cls == CLS_RD);
                end
            end else if (finishing) begin
                op_q.busy <= 1'b0;
                op_done   <= 1'b1;
            end else if (preempt) begin
                op_q.busy     <= 1'b0;
                op_abort      <= 1'b1;
                preempt_total <= preempt_total + 1'b1;
            end else begin
                elapsed <= elapsed + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bank_req_sched_chk.sv
module bank_req_sched_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            op_done,
    input logic            op_abort,
    input logic [PC_W-1:0] preempt_total,
    input logic            busy,
    input logic [1:0]      cur_cls
);
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(op_done && op_abort)); // R5
    AST_NO_GRANT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_abort) |-> !cmd_valid); // R8
    AST_GRANT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (busy && !$past(busy))); // R8
    AST_READ_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
        op_abort |-> ($past(cur_cls) != 2'd0)); // R7
    AST_PREEMPT_STEP: assert property (@(posedge clk) disable iff (rst)
        op_abort |-> (preempt_total == PC_W'($past(preempt_total) + 1'b1))); // R9
    AST_PREEMPT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_abort |-> $stable(preempt_total)); // R9
endmodule

bind bank_req_sched bank_req_sched_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .op_done       (op_done),
    .op_abort      (op_abort),
    .preempt_total (preempt_total),
    .busy          (busy_w),
    .cur_cls       (cur_cls_w)
);

// File: tb/bank_req_sched_test.sv
module bank_req_sched_test;
    localparam int AW = 16;
    localparam int RDL = 12;
    localparam int WRL = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tie_top = 1'b0;
    logic [3:0]    req_valid = '0;
    logic [3:0]    req_ready;
    logic [4*AW-1:0] req_addr = '0;
    logic          cmd_valid, op_done, op_abort;
    logic [1:0]    cmd_cls;
    logic [AW-1:0] cmd_addr;
    logic [15:0]   preempt_total;

    bank_req_sched uut (
        .clk(clk), .rst(rst), .tie_top(tie_top),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .cmd_valid(cmd_valid), .cmd_cls(cmd_cls), .cmd_addr(cmd_addr),
        .op_done(op_done), .op_abort(op_abort), .preempt_total(preempt_total)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int cmd_c [256]; int cmd_k [256]; int cmd_a [256]; int ncmd = 0;
    int done_c [256]; int nd = 0;
    int abort_c [256]; int nab = 0;
    int nchk = 0; int nerr = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                cmd_c[ncmd] = cyc; cmd_k[ncmd] = int'(cmd_cls);
                cmd_a[ncmd] = int'(cmd_addr); ncmd++;
            end
            if (op_done)  begin done_c[nd] = cyc; nd++; end
            if (op_abort) begin abort_c[nab] = cyc; nab++; end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic push(logic [3:0] m, int a0, int a1, int a2, int a3);
        req_valid = m;
        req_addr  = {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
        step();
        req_valid = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R10", "cmd_valid in reset", int'(cmd_valid), 0);
        chk("R10", "ready in reset", int'(req_ready), 15);
        chk("R10", "count in reset", int'(preempt_total), 0);
        chk("R10", "done/abort in reset", int'(op_done | op_abort), 0);
        rst = 1'b0;
        step();
    endtask

    task automatic wait_cmds(int n);
        while (ncmd < n) step();
    endtask

    task automatic wait_dones(int n);
        while (nd < n) step();
    endtask

    task automatic t_strict_all();
        int b, bd;
        do_reset(); tie_top = 1'b0;
        b = ncmd; bd = nd;
        push(4'hF, 'h100, 'h101, 'h102, 'h103);
        wait_dones(bd + 4);
        for (int i = 0; i < 4; i++) begin
            chk("R1", "strict class order", cmd_k[b+i], i);
            chk("R1", "strict address", cmd_a[b+i], 'h100 + i);
        end
        chk("R4", "read latency", done_c[bd] - cmd_c[b], RDL);
        chk("R4", "fill latency", done_c[bd+1] - cmd_c[b+1], WRL);
        chk("R4", "writeback latency", done_c[bd+3] - cmd_c[b+3], WRL);
        chk("R8", "grant after done", cmd_c[b+1], done_c[bd] + 1);
        chk("R9", "no preemption", int'(preempt_total), 0);
    endtask

    task automatic t_fifo_order();
        int b, bd;
        do_reset(); tie_top = 1'b0;
        b = ncmd; bd = nd;
        for (int i = 0; i < 4; i++) push(4'b1000, 0, 0, 0, 'h200 + i);
        chk("R3", "ready low when full", int'(req_ready[3]), 0);
        wait_dones(bd + 4);
        for (int i = 0; i < 4; i++) chk("R3", "in-class order", cmd_a[b+i], 'h200 + i);
        step();
        chk("R3", "ready back when drained", int'(req_ready[3]), 1);
    endtask

    task automatic t_two_pairs(logic tie, logic with_pf);
        int b, bd, nab0;
        int exp_k [5];
        int exp_a [5];
        do_reset(); tie_top = tie;
        b = ncmd; bd = nd; nab0 = nab;
        push(with_pf ? 4'b0111 : 4'b0011, 'h300, 'h310, 'h320, 0);
        push(4'b0011, 'h301, 'h311, 0, 0);
        wait_dones(bd + (with_pf ? 5 : 4));
        if (tie) begin
            exp_k = '{0, 1, 0, 1, 2}; exp_a = '{'h300, 'h310, 'h301, 'h311, 'h320};
        end else begin
            exp_k = '{0, 0, 1, 1, 2}; exp_a = '{'h300, 'h301, 'h310, 'h311, 'h320};
        end
        for (int i = 0; i < (with_pf ? 5 : 4); i++) begin
            chk(tie ? "R2" : "R1", "pair class order", cmd_k[b+i], exp_k[i]);
            chk(tie ? "R2" : "R1", "pair address", cmd_a[b+i], exp_a[i]);
        end
        chk("R7", "read with queued fill not aborted", nab - nab0, 0);
        chk("R7", "read full latency", done_c[bd] - cmd_c[b], RDL);
    endtask

    // Victim class v in service; class p arrives k cycles after its grant.
    task automatic t_preempt(string req, int v, int p, int k, logic exp_ab);
        int b, bd, nab0, c, cnt0;
        do_reset(); tie_top = 1'b0;
        b = ncmd; bd = nd; nab0 = nab; cnt0 = int'(preempt_total);
        push(4'(1 << v), 'h400, 'h400, 'h400, 'h400);
        push(4'(1 << v), 'h401, 'h401, 'h401, 'h401);
        wait_cmds(b + 1);
        c = cmd_c[b];
        repeat (k) step();
        push(4'(1 << p), 'h4F0, 'h4F0, 'h4F0, 'h4F0);
        wait_cmds(b + (exp_ab ? 4 : 3));
        wait_dones(bd + 3);
        if (exp_ab) begin
            chk(req, "abort seen", nab - nab0, 1);
            chk(req, "abort cycle", abort_c[nab0], c + k + 2);
            chk("R9", "count step", int'(preempt_total) - cnt0, 1);
            chk("R8", "preemptor grant cycle", cmd_c[b+1], c + k + 3);
            chk(req, "preemptor class", cmd_k[b+1], p);
            chk("R6", "retry class", cmd_k[b+2], v);
            chk("R6", "retry address", cmd_a[b+2], 'h400);
            chk("R6", "younger after retry", cmd_a[b+3], 'h401);
            chk("R4", "retry full latency", done_c[bd+1] - cmd_c[b+2], WRL);
        end else begin
            chk(req, "no abort", nab - nab0, 0);
            chk("R4", "write completes", done_c[bd], c + WRL);
            chk("R8", "next grant cycle", cmd_c[b+1], c + WRL + 1);
            chk(req, "waiting class next", cmd_k[b+1], p);
            chk("R3", "younger next", cmd_a[b+2], 'h401);
            chk("R9", "count unchanged", int'(preempt_total) - cnt0, 0);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr);
        $finish;
    end

    initial begin
        t_strict_all();
        t_fifo_order();
        t_two_pairs(1'b1, 1'b1);
        t_two_pairs(1'b0, 1'b0);
        t_preempt("R5", 3, 0, 3, 1'b1);
        t_preempt("R5", 3, 0, 4, 1'b0);
        t_preempt("R5", 1, 0, 10, 1'b1);
        t_preempt("R5", 1, 0, 11, 1'b0);
        t_preempt("R5", 2, 1, 2, 1'b1);
        t_preempt("R5", 3, 2, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule